// File: doc/BRIEF.md
# Endpoint FIFO CPU Access Port

This block is the processor-side data window into the packet buffers of a USB device controller. Each endpoint owns a small byte buffer with a write pointer and a read pointer. A control register picks one endpoint, and a data register then reads bytes from that buffer or writes bytes into it. An access moves one 16-bit word or one byte. In word mode the byte order is selectable. A rewind command returns the relevant pointer of the selected buffer to its start.

The access width is byte-wide when any one of three sources asks for it: a board-level strap pin, a global control bit, or a per-endpoint configuration input. For an endpoint configured as receive (host to device), rewind moves the read pointer so the received data can be read again. For a transmit endpoint, rewind moves the write pointer, which discards the data written so far. A byte-write port on the engine side lets receive data be loaded into any buffer. Accesses are blocked when the processor selects the same endpoint as the DMA channel. Reads past the written data and writes past the buffer capacity set sticky flags.

Top module: `fifo_cpu_port`

## Requirements
- R1: Register address 0 is the control register and address 1 is the data register. Control bits [3:0] select the endpoint. A selection of NUM_EP or above reaches no buffer: data reads return 0, data writes are dropped, and no flag is set. After reset the control register reads 0x0000.
- R2: With control bit 5 (swap) at 0, the word holds the lower-addressed byte on bits [7:0] and the next byte on bits [15:8]. This applies to both reads and writes.
- R3: With swap at 1 in word mode, the lower-addressed byte is on bits [15:8] and the next byte is on bits [7:0].
- R4: The access is byte-wide when the strap pin, control bit 4 or the selected endpoint's `ep_octl` bit is 1. A byte read returns the byte on [7:0] with [15:8] at 0, and a byte write stores bits [7:0].
- R5: While the strap pin is 1, control bit 4 reads back as 0.
- R6: In byte mode the swap bit has no effect on the data. The swap bit still reads back as written.
- R7: Writing 1 to control bit 8 on a receive endpoint (`ep_dir` bit 0) returns its read pointer to 0, so data already read can be read again.
- R8: Writing 1 to control bit 8 on a transmit endpoint (`ep_dir` bit 1) returns its write pointer to 0, so the bytes written earlier are discarded.
- R9: Rewind acts at the clock edge after the control write and always reads back as 0.
- R10: A word access advances the pointer by 2 bytes and a byte access advances it by 1.
- R11: When `dma_sel_vld` is 1 and `dma_sel` equals the selected endpoint, `conflict` is 1 and control bit 11 reads 1. Data accesses are then ignored (reads return 0, pointers hold) until the selection differs.
- R12: A read that needs more bytes than have been written returns 0 and leaves the read pointer in place. It sets the sticky `underrun` flag (control bit 10), which is cleared by writing 1 to that bit.
- R13: A write that does not fit in BUF_BYTES is dropped whole. It sets the sticky `overrun` flag (control bit 9), which is cleared by writing 1 to that bit.
- R14: Read data and `reg_rvld` appear on the clock edge after the one that samples `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_8bit | input | 1 | Pin strap forcing byte access |
| ep_dir | input | NUM_EP | Per-endpoint direction, 1 = transmit |
| ep_octl | input | NUM_EP | Per-endpoint byte-mode request |
| dma_sel_vld | input | 1 | DMA channel endpoint selection is active |
| dma_sel | input | 4 | Endpoint in use by the DMA channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = control, 1 = data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| reg_rvld | output | 1 | Read data valid |
| eng_wr | input | 1 | Engine-side byte write strobe |
| eng_ep | input | 4 | Engine-side target endpoint |
| eng_byte | input | 8 | Engine-side byte |
| conflict | output | 1 | Processor and DMA selections collide |
| overrun | output | 1 | Sticky write overflow flag |
| underrun | output | 1 | Sticky read underflow flag |

## Verification
The bench builds the block with NUM_EP = 4 and BUF_BYTES = 8. With an 8-byte buffer, four word writes fill an endpoint, so the dropped fifth write and the overrun flag are reached in a few cycles. With four endpoints behind a 4-bit select, selections 4 to 15 reach no buffer, which exercises the out-of-range path. One endpoint is configured as transmit and one as byte-only, so both rewind directions and the per-endpoint width source are covered.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam int SEL_W   = 4;
  localparam int CB_SEL  = 0;
  localparam int CB_BYTE = 4;
  localparam int CB_SWAP = 5;
  localparam int CB_REW  = 8;
  localparam int CB_OVR  = 9;
  localparam int CB_UND  = 10;
  localparam int CB_CONF = 11;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             byte_g;
    logic             swap;
  } cfg_t;
endpackage

// File: rtl/fcp_ctrl.sv
module fcp_ctrl
  import fcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             byte_i,
  input  logic             swap_i,
  input  logic             rew_i,
  input  logic             ovr_clr_i,
  input  logic             und_clr_i,
  input  logic             strap_i,
  input  logic             conflict_i,
  input  logic             ovr_evt_i,
  input  logic             und_evt_i,
  output cfg_t             cfg_o,
  output logic             rew_o,
  output logic             ovr_o,
  output logic             und_o,
  output logic [15:0]      rdata_o
);
  cfg_t cfg_q, cfg_d;
  logic rew_q, rew_d, ovr_q, ovr_d, und_q, und_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) begin
      cfg_d.sel    = sel_i;
      cfg_d.byte_g = byte_i;
      cfg_d.swap   = swap_i;
    end
    rew_d = wr_i & rew_i;
    ovr_d = (ovr_q & ~(wr_i & ovr_clr_i)) | ovr_evt_i;
    und_d = (und_q & ~(wr_i & und_clr_i)) | und_evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rew_q <= 1'b0;
      ovr_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      rew_q <= rew_d;
      ovr_q <= ovr_d;
      und_q <= und_d;
    end
  end

  always_comb begin
    rdata_o                  = '0;
    rdata_o[CB_SEL+:SEL_W]   = cfg_q.sel;
    rdata_o[CB_BYTE]         = cfg_q.byte_g & ~strap_i;
    rdata_o[CB_SWAP]         = cfg_q.swap;
    rdata_o[CB_OVR]          = ovr_q;
    rdata_o[CB_UND]          = und_q;
    rdata_o[CB_CONF]         = conflict_i;
  end

  assign cfg_o = cfg_q;
  assign rew_o = rew_q;
  assign ovr_o = ovr_q;
  assign und_o = und_q;

  // R12
  und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    und_q && !(wr_i && und_clr_i) |=> und_q);
  // R13
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !(wr_i && ovr_clr_i) |=> ovr_q);
  // R9
  rew_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rew_q && !wr_i |=> !rew_q);
endmodule

// File: rtl/fcp_lane.sv
module fcp_lane (
  input  logic        byte_i,
  input  logic        swap_i,
  input  logic [7:0]  rd_b0_i,
  input  logic [7:0]  rd_b1_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rword_o,
  output logic [7:0]  wr_b0_o,
  output logic [7:0]  wr_b1_o
);
  logic swap_eff;

  assign swap_eff = swap_i & ~byte_i;

  always_comb begin
    if (byte_i)        rword_o = {8'h00, rd_b0_i};
    else if (swap_eff) rword_o = {rd_b0_i, rd_b1_i};
    else               rword_o = {rd_b1_i, rd_b0_i};
    wr_b0_o = swap_eff ? wdata_i[15:8] : wdata_i[7:0];
    wr_b1_o = swap_eff ? wdata_i[7:0]  : wdata_i[15:8];
  end
endmodule

// File: rtl/fcp_ep_buf.sv
module fcp_ep_buf #(
  parameter int BUF_BYTES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_i,
  input  logic       rewind_i,
  input  logic       two_i,
  input  logic       wr_i,
  input  logic [7:0] wr_b0_i,
  input  logic [7:0] wr_b1_i,
  input  logic       rd_i,
  input  logic       eng_wr_i,
  input  logic [7:0] eng_b_i,
  output logic [7:0] rd_b0_o,
  output logic [7:0] rd_b1_o,
  output logic       wr_fit_o,
  output logic       rd_ok_o
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int PW = AW + 1;
  localparam logic [PW:0] CAP = (PW+1)'(BUF_BYTES);

  logic [7:0]    mem [BUF_BYTES];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d, step;
  logic [PW:0]   wsum, rsum;
  logic [AW-1:0] widx, widx1, ridx, ridx1;
  logic          cpu_we, eng_we;

  assign step  = two_i ? PW'(2) : PW'(1);
  assign wsum  = {1'b0, wptr_q} + {1'b0, step};
  assign rsum  = {1'b0, rptr_q} + {1'b0, step};
  assign wr_fit_o = (wsum <= CAP);
  assign rd_ok_o  = (rsum <= {1'b0, wptr_q});
  assign widx  = wptr_q[AW-1:0];
  assign widx1 = widx + AW'(1);
  assign ridx  = rptr_q[AW-1:0];
  assign ridx1 = ridx + AW'(1);
  assign cpu_we = !rewind_i && wr_i && wr_fit_o;
  assign eng_we = !rewind_i && !cpu_we && eng_wr_i && ({1'b0, wptr_q} < CAP);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (rewind_i) begin
      if (dir_i) wptr_d = '0;
      else       rptr_d = '0;
    end else begin
      if (cpu_we)      wptr_d = wsum[PW-1:0];
      else if (eng_we) wptr_d = wptr_q + PW'(1);
      if (rd_i && rd_ok_o) rptr_d = rsum[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_we) begin
      mem[widx] <= wr_b0_i;
      if (two_i) mem[widx1] <= wr_b1_i;
    end else if (eng_we) begin
      mem[widx] <= eng_b_i;
    end
  end

  assign rd_b0_o = mem[ridx];
  assign rd_b1_o = mem[ridx1];

  // R8
  tx_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_i && dir_i |=> wptr_q == '0);
  // R7
  rx_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_i && !dir_i |=> rptr_q == '0);
  // R13
  wptr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, wptr_q} <= CAP);
  // R11
  rptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i && !rewind_i |=> $stable(rptr_q));
endmodule

// File: rtl/fifo_cpu_port.sv
module fifo_cpu_port
  import fcp_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int BUF_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_8bit,
  input  logic [NUM_EP-1:0] ep_dir,
  input  logic [NUM_EP-1:0] ep_octl,
  input  logic              dma_sel_vld,
  input  logic [3:0]        dma_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              reg_rvld,
  input  logic              eng_wr,
  input  logic [3:0]        eng_ep,
  input  logic [7:0]        eng_byte,
  output logic              conflict,
  output logic              overrun,
  output logic              underrun
);
  cfg_t              cfg;
  logic              rew_pulse, ctrl_wr, data_wr, data_rd;
  logic              sel_ok, blocked, byte_eff, conf;
  logic              ovr_evt, und_evt;
  logic [15:0]       ctrl_rd, rword, rdata_q, rdata_d;
  logic              rvld_q;
  logic [7:0]        wr_b0, wr_b1, sel_b0, sel_b1;
  logic              sel_fit, sel_rdok, sel_octl;
  logic [NUM_EP-1:0] hit;
  logic [7:0]        b0_a [NUM_EP];
  logic [7:0]        b1_a [NUM_EP];
  logic [NUM_EP-1:0] fit_a, rdok_a;

  assign ctrl_wr  = reg_wr & ~reg_addr;
  assign data_wr  = reg_wr & reg_addr;
  assign data_rd  = reg_rd & reg_addr;
  assign conf     = dma_sel_vld & (dma_sel == cfg.sel);
  assign sel_ok   = |hit;
  assign blocked  = conf | ~sel_ok;
  assign byte_eff = strap_8bit | cfg.byte_g | sel_octl;
  assign ovr_evt  = data_wr & ~blocked & ~sel_fit;
  assign und_evt  = data_rd & ~blocked & ~sel_rdok;

  fcp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (ctrl_wr),
    .sel_i      (reg_wdata[CB_SEL+:SEL_W]),
    .byte_i     (reg_wdata[CB_BYTE]),
    .swap_i     (reg_wdata[CB_SWAP]),
    .rew_i      (reg_wdata[CB_REW]),
    .ovr_clr_i  (reg_wdata[CB_OVR]),
    .und_clr_i  (reg_wdata[CB_UND]),
    .strap_i    (strap_8bit),
    .conflict_i (conf),
    .ovr_evt_i  (ovr_evt),
    .und_evt_i  (und_evt),
    .cfg_o      (cfg),
    .rew_o      (rew_pulse),
    .ovr_o      (overrun),
    .und_o      (underrun),
    .rdata_o    (ctrl_rd)
  );

  fcp_lane u_lane (
    .byte_i  (byte_eff),
    .swap_i  (cfg.swap),
    .rd_b0_i (sel_b0),
    .rd_b1_i (sel_b1),
    .wdata_i (reg_wdata),
    .rword_o (rword),
    .wr_b0_o (wr_b0),
    .wr_b1_o (wr_b1)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign hit[e] = (cfg.sel == 4'(e));
    fcp_ep_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_i    (ep_dir[e]),
      .rewind_i (rew_pulse & hit[e]),
      .two_i    (~byte_eff),
      .wr_i     (data_wr & ~conf & hit[e]),
      .wr_b0_i  (wr_b0),
      .wr_b1_i  (wr_b1),
      .rd_i     (data_rd & ~conf & hit[e]),
      .eng_wr_i (eng_wr & (eng_ep == 4'(e))),
      .eng_b_i  (eng_byte),
      .rd_b0_o  (b0_a[e]),
      .rd_b1_o  (b1_a[e]),
      .wr_fit_o (fit_a[e]),
      .rd_ok_o  (rdok_a[e])
    );
  end

  always_comb begin
    sel_b0   = '0;
    sel_b1   = '0;
    sel_fit  = 1'b0;
    sel_rdok = 1'b0;
    sel_octl = 1'b0;
    for (int e = 0; e < NUM_EP; e++) begin
      if (hit[e]) begin
        sel_b0   = b0_a[e];
        sel_b1   = b1_a[e];
        sel_fit  = fit_a[e];
        sel_rdok = rdok_a[e];
        sel_octl = ep_octl[e];
      end
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_addr) rdata_d = (blocked || !sel_rdok) ? 16'h0000 : rword;
    else          rdata_d = ctrl_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q <= reg_rd;
      if (reg_rd) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign reg_rvld  = rvld_q;
  assign conflict  = conf;

  // R11
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && conf |=> reg_rdata == 16'h0000);
  // R4
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && byte_eff |=> reg_rdata[15:8] == 8'h00);
  // R5
  strap_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_addr && strap_8bit |=> !reg_rdata[CB_BYTE]);
  // R14
  rvld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvld);
  // R9
  rew_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_addr |=> !reg_rdata[CB_REW]);
endmodule

// File: tb/sim_fifo_cpu_port.sv
`timescale 1ns/1ps
module sim_fifo_cpu_port;
  localparam int NEP = 4;
  localparam int BB  = 8;
  localparam int NV  = 47;
  // entry: {req[3:0], op[1:0], addr, wdata[15:0], expect[15:0]}
  // op 0 = register write, 1 = register read and compare, 2 = engine byte (wdata[11:8] ep)
  localparam logic [38:0] VEC [NV] = '{
    {4'd1, 2'd2, 1'b0, 16'h0011, 16'h0000},  // R1 preload ep0
    {4'd1, 2'd2, 1'b0, 16'h0022, 16'h0000},
    {4'd1, 2'd2, 1'b0, 16'h0033, 16'h0000},
    {4'd1, 2'd2, 1'b0, 16'h0044, 16'h0000},
    {4'd1, 2'd0, 1'b0, 16'h0000, 16'h0000},  // select ep0, word, little
    {4'd2, 2'd1, 1'b1, 16'h0000, 16'h2211},  // R2
    {4'd3, 2'd0, 1'b0, 16'h0020, 16'h0000},
    {4'd3, 2'd1, 1'b1, 16'h0000, 16'h3344},  // R3
    {4'd7, 2'd0, 1'b0, 16'h0100, 16'h0000},
    {4'd7, 2'd1, 1'b1, 16'h0000, 16'h2211},  // R7 reread
    {4'd4, 2'd0, 1'b0, 16'h0010, 16'h0000},
    {4'd10,2'd1, 1'b1, 16'h0000, 16'h0033},  // R10 byte step
    {4'd10,2'd1, 1'b1, 16'h0000, 16'h0044},
    {4'd12,2'd1, 1'b1, 16'h0000, 16'h0000},  // R12 underrun
    {4'd12,2'd1, 1'b0, 16'h0000, 16'h0410},
    {4'd12,2'd0, 1'b0, 16'h0400, 16'h0000},
    {4'd12,2'd1, 1'b0, 16'h0000, 16'h0000},
    {4'd8, 2'd0, 1'b0, 16'h0001, 16'h0000},  // R8 ep1 transmit
    {4'd8, 2'd0, 1'b1, 16'hA1B2, 16'h0000},
    {4'd8, 2'd0, 1'b1, 16'hC3D4, 16'h0000},
    {4'd8, 2'd0, 1'b0, 16'h0101, 16'h0000},
    {4'd9, 2'd1, 1'b0, 16'h0000, 16'h0001},  // R9 rewind reads 0
    {4'd8, 2'd0, 1'b1, 16'h5566, 16'h0000},
    {4'd8, 2'd1, 1'b1, 16'h0000, 16'h5566},
    {4'd8, 2'd1, 1'b1, 16'h0000, 16'h0000},
    {4'd8, 2'd0, 1'b0, 16'h0401, 16'h0000},
    {4'd4, 2'd0, 1'b0, 16'h0002, 16'h0000},  // R4 ep2 byte via ep_octl
    {4'd4, 2'd0, 1'b1, 16'hBEEF, 16'h0000},
    {4'd4, 2'd1, 1'b1, 16'h0000, 16'h00EF},
    {4'd6, 2'd0, 1'b0, 16'h0022, 16'h0000},  // R6 swap ignored
    {4'd6, 2'd0, 1'b1, 16'h1234, 16'h0000},
    {4'd6, 2'd1, 1'b1, 16'h0000, 16'h0034},
    {4'd6, 2'd1, 1'b0, 16'h0000, 16'h0022},
    {4'd13,2'd0, 1'b0, 16'h0003, 16'h0000},  // R13 ep3 fill
    {4'd13,2'd0, 1'b1, 16'h0102, 16'h0000},
    {4'd13,2'd0, 1'b1, 16'h0304, 16'h0000},
    {4'd13,2'd0, 1'b1, 16'h0506, 16'h0000},
    {4'd13,2'd0, 1'b1, 16'h0708, 16'h0000},
    {4'd13,2'd0, 1'b1, 16'h0909, 16'h0000},
    {4'd13,2'd1, 1'b0, 16'h0000, 16'h0203},
    {4'd10,2'd1, 1'b1, 16'h0000, 16'h0102},
    {4'd10,2'd1, 1'b1, 16'h0000, 16'h0304},
    {4'd10,2'd1, 1'b1, 16'h0000, 16'h0506},
    {4'd10,2'd1, 1'b1, 16'h0000, 16'h0708},
    {4'd13,2'd1, 1'b1, 16'h0000, 16'h0000},
    {4'd13,2'd0, 1'b0, 16'h0600, 16'h0000},
    {4'd13,2'd1, 1'b0, 16'h0000, 16'h0000}
  };

  logic clk, rst_n, strap_8bit, dma_sel_vld, reg_wr, reg_rd, reg_addr, eng_wr;
  logic [NEP-1:0] ep_dir, ep_octl;
  logic [3:0]  dma_sel, eng_ep;
  logic [15:0] reg_wdata, reg_rdata;
  logic [7:0]  eng_byte;
  logic reg_rvld, conflict, overrun, underrun;
  int n_run, n_fail;
  logic [15:0] got;

  fifo_cpu_port #(.NUM_EP(NEP), .BUF_BYTES(BB)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_8bit(strap_8bit), .ep_dir(ep_dir),
    .ep_octl(ep_octl), .dma_sel_vld(dma_sel_vld), .dma_sel(dma_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvld(reg_rvld),
    .eng_wr(eng_wr), .eng_ep(eng_ep), .eng_byte(eng_byte),
    .conflict(conflict), .overrun(overrun), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_rd(input logic a, output logic [15:0] q);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    q = reg_rdata;
  endtask

  task automatic do_eng(input logic [3:0] ep, input logic [7:0] b);
    @(negedge clk);
    eng_wr = 1'b1; eng_ep = ep; eng_byte = b;
    @(negedge clk);
    eng_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; strap_8bit = 1'b0; dma_sel_vld = 1'b0; dma_sel = 4'd0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    eng_wr = 1'b0; eng_ep = '0; eng_byte = '0;
    ep_dir = 4'b0010; ep_octl = 4'b0100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset rdata", reg_rdata, 16'h0000);
    check("R13 reset flags", {13'd0, conflict, overrun, underrun}, 16'h0000);
    do_rd(1'b0, got);
    check("R1 reset ctrl", got, 16'h0000);
    // R14 latency
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 1'b0;
    @(negedge clk);
    reg_rd = 1'b0;
    check("R14 rvld after edge", {15'd0, reg_rvld}, 16'h0001);
    @(negedge clk);
    check("R14 rvld drops", {15'd0, reg_rvld}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      case (v[34:33])
        2'd0: do_wr(v[32], v[31:16]);
        2'd1: begin
          do_rd(v[32], got);
          n_run++;
          if (got !== v[15:0]) begin
            n_fail++;
            $display("FAIL R%0d vector %0d actual=%h expected=%h", v[38:35], i, got, v[15:0]);
          end
        end
        default: do_eng(v[27:24], v[23:16]);
      endcase
    end

    // R11 conflict blocks access
    dma_sel_vld = 1'b1; dma_sel = 4'd0;
    do_wr(1'b0, 16'h0100);
    check("R11 conflict port", {15'd0, conflict}, 16'h0001);
    do_rd(1'b0, got);
    check("R11 conflict ctrl bit", got, 16'h0800);
    do_rd(1'b1, got);
    check("R11 blocked read", got, 16'h0000);
    check("R11 no underrun", {15'd0, underrun}, 16'h0000);
    dma_sel = 4'd2;
    @(negedge clk);
    check("R11 conflict clears", {15'd0, conflict}, 16'h0000);
    do_rd(1'b1, got);
    check("R11 pointer held", got, 16'h2211);
    dma_sel_vld = 1'b0;
    // R1 out-of-range select
    do_wr(1'b0, 16'h0004);
    do_rd(1'b1, got);
    check("R1 unpopulated read", got, 16'h0000);
    do_wr(1'b1, 16'hFFFF);
    check("R1 no flags", {14'd0, overrun, underrun}, 16'h0000);
    // R5 strap forces byte mode, global bit reads 0
    strap_8bit = 1'b1;
    do_wr(1'b0, 16'h0110);
    do_rd(1'b0, got);
    check("R5 strap masks byte bit", got, 16'h0000);
    do_rd(1'b1, got);
    check("R4 strap byte read", got, 16'h0011);
    strap_8bit = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule